// File: doc/BRIEF.md
# Overlapping 0101 Serial Sequence Detector

This block watches a one-bit serial stream, one bit per clock, and raises a one-bit flag in the same cycle as the bit that completes the sequence 0, 1, 0, 1. The flag is a Mealy output. It comes from both the stored state and the live input bit, so the match is reported without waiting for the next clock edge. Occurrences may overlap. After a match, the final "01" already counts as the start of the next occurrence, so the stream 010101 reports two matches.

The machine has four abstract states: idle (A), seen "0" (B), seen "01" (C) and seen "010" (D). It uses a present-state register, a state decoder and a step function that computes the next state and the match. A parameter chooses how the four states are stored: binary, Gray or one-hot. The sequence of flags at the output is the same for every choice.

Top module: `seq0101_det`

## Requirements
- R1: A synchronous active-high reset puts the machine in state A. Bits that arrive after reset cannot combine with bits that came before it.
- R2: While reset is high, `z` is 0 whatever the input bit and the stored state.
- R3: `z` is 1 in the same cycle as the `x` bit that ends the sequence 0,1,0,1 (oldest first), counted since the last reset. In every other cycle `z` is 0.
- R4: Detection overlaps. After a match the machine moves to state C (seen "01"), so each further "01" pair gives another match. For example, 010101 matches at bits 4 and 6.
- R5: The state moves are as follows. From A, a 0 goes to B and a 1 stays in A. From B, a 0 stays in B and a 1 goes to C. From C, a 0 goes to D and a 1 goes to A. From D, a 1 goes to C (match) and a 0 goes to B.
- R6: Parameter `ENC` selects the state codes. ENC_BIN uses A=00, B=01, C=10, D=11. ENC_GRAY uses A=00, B=01, C=11, D=10. ENC_ONEHOT uses A=1000, B=0100, C=0010, D=0001. The output sequence is the same for all three.
- R7: Outside reset, the state register always holds a legal code for the selected encoding. For one-hot this means exactly one bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit |
| z | output | 1 | Match flag (Mealy) |

## Verification
The bench builds three instances side by side, one each with `ENC` set to ENC_BIN, ENC_GRAY and ENC_ONEHOT, and drives them with the same stream. This exposes any encoding-dependent fault as a disagreement with the shared reference. It also lets the one-hot legality check and the Gray code table be exercised in the same run. The reference is a history of the last three bits since reset, which is independent of the state table. The stimulus covers directed chains of overlapping matches, resets placed in the middle of a pattern, and a long random stream with occasional resets.

// File: rtl/seq_det_pkg.sv
package seq_det_pkg;

  typedef enum logic [1:0] {
    ENC_BIN    = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } enc_e;

  // abstract state index: 0=A idle, 1=B "0", 2=C "01", 3=D "010"
  localparam logic [1:0] ST_A = 2'd0;
  localparam logic [1:0] ST_B = 2'd1;
  localparam logic [1:0] ST_C = 2'd2;
  localparam logic [1:0] ST_D = 2'd3;

  function automatic int state_width(enc_e e);
    return (e == ENC_ONEHOT) ? 4 : 2;
  endfunction

  // abstract index -> stored code (right aligned in 4 bits)
  function automatic logic [3:0] encode(enc_e e, logic [1:0] idx);
    logic [3:0] c;
    case (e)
      ENC_GRAY:   c = {2'b00, idx[1], idx[1] ^ idx[0]};
      ENC_ONEHOT: c = 4'b1000 >> idx;
      default:    c = {2'b00, idx};
    endcase
    return c;
  endfunction

  // stored code -> {legal, abstract index}; an illegal code maps to A
  function automatic logic [2:0] decode(enc_e e, logic [3:0] c);
    logic [2:0] r;
    case (e)
      ENC_GRAY:   r = {1'b1, c[1], c[1] ^ c[0]};
      ENC_ONEHOT: begin
        case (c)
          4'b1000: r = {1'b1, ST_A};
          4'b0100: r = {1'b1, ST_B};
          4'b0010: r = {1'b1, ST_C};
          4'b0001: r = {1'b1, ST_D};
          default: r = {1'b0, ST_A};
        endcase
      end
      default:    r = {1'b1, c[1:0]};
    endcase
    return r;
  endfunction

  // transition: {match, next index}
  function automatic logic [2:0] step(logic [1:0] idx, logic b);
    logic [2:0] r;
    case (idx)
      ST_A:    r = b ? {1'b0, ST_A} : {1'b0, ST_B};
      ST_B:    r = b ? {1'b0, ST_C} : {1'b0, ST_B};
      ST_C:    r = b ? {1'b0, ST_A} : {1'b0, ST_D};
      default: r = b ? {1'b1, ST_C} : {1'b0, ST_B};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/s5_state_reg.sv
module s5_state_reg #(
  parameter int               SW       = 2,
  parameter logic [SW-1:0]    RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_CODE;
    else     q <= d;
  end
endmodule

// File: rtl/s5_decode.sv
module s5_decode #(
  parameter seq_det_pkg::enc_e ENC = seq_det_pkg::ENC_BIN,
  parameter int                SW  = 2
) (
  input  logic [SW-1:0] code,
  output logic [1:0]    idx,
  output logic          legal
);
  logic [2:0] dec;
  always_comb begin
    dec   = seq_det_pkg::decode(ENC, 4'(code));
    legal = dec[2];
    idx   = dec[1:0];
  end
endmodule

// File: rtl/s5_step.sv
module s5_step #(
  parameter seq_det_pkg::enc_e ENC = seq_det_pkg::ENC_BIN,
  parameter int                SW  = 2
) (
  input  logic [1:0]    idx,
  input  logic          x,
  output logic [1:0]    nxt_idx,
  output logic [SW-1:0] nxt_code,
  output logic          hit
);
  logic [2:0] res;
  always_comb begin
    res      = seq_det_pkg::step(idx, x);
    hit      = res[2];
    nxt_idx  = res[1:0];
    nxt_code = SW'(seq_det_pkg::encode(ENC, res[1:0]));
  end
endmodule

// File: rtl/seq0101_det.sv
module seq0101_det #(
  parameter seq_det_pkg::enc_e ENC = seq_det_pkg::ENC_BIN
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  localparam int            SW       = seq_det_pkg::state_width(ENC);
  localparam logic [SW-1:0] RST_CODE = SW'(seq_det_pkg::encode(ENC, seq_det_pkg::ST_A));

  logic [SW-1:0] cur_code;
  logic [SW-1:0] nxt_code;
  logic [1:0]    cur_idx;
  logic [1:0]    nxt_idx;
  logic          code_legal;
  logic          hit;

  s5_state_reg #(.SW(SW), .RST_CODE(RST_CODE)) u_reg (
    .clk (clk), .rst (rst), .d (nxt_code), .q (cur_code)
  );

  s5_decode #(.ENC(ENC), .SW(SW)) u_dec (
    .code (cur_code), .idx (cur_idx), .legal (code_legal)
  );

  s5_step #(.ENC(ENC), .SW(SW)) u_step (
    .idx (cur_idx), .x (x), .nxt_idx (nxt_idx), .nxt_code (nxt_code), .hit (hit)
  );

  assign z = hit & ~rst;

  // R1: reset lands in state A
  a_r1_reset_to_a: assert property (@(posedge clk) rst |=> (cur_idx == seq_det_pkg::ST_A));

  // R2: flag silent under reset
  always @(posedge clk) begin
    if (rst) a_r2_quiet_in_reset: assert (z == 1'b0);
  end

  // R3: a match only completes from D on a 1
  a_r3_hit_from_d: assert property (@(posedge clk) disable iff (rst)
    z |-> (cur_idx == seq_det_pkg::ST_D && x));

  // R4: after a match the machine keeps the trailing "01"
  a_r4_overlap_to_c: assert property (@(posedge clk) disable iff (rst)
    z |=> (cur_idx == seq_det_pkg::ST_C));

  // R5: a 0 input never leaves the machine in A or C
  a_r5_zero_moves: assert property (@(posedge clk) disable iff (rst)
    !x |=> (cur_idx == seq_det_pkg::ST_B || cur_idx == seq_det_pkg::ST_D));

  // R7: stored code is legal for the chosen encoding
  a_r7_code_legal: assert property (@(posedge clk) disable iff (rst) code_legal);

  generate
    if (ENC == seq_det_pkg::ENC_ONEHOT) begin : g_oh_chk
      // R7: one-hot keeps exactly one bit set
      a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(cur_code) == 1);
    end
  endgenerate

endmodule

// File: tb/tb_seq0101_det.sv
module tb_seq0101_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z_b, z_g, z_h;

  int total = 0;
  int bad   = 0;

  // reference: bits since reset, newest in bit 0
  logic [2:0] hist = '0;
  int         seen = 0;

  always #5 clk = ~clk;

  seq0101_det #(.ENC(seq_det_pkg::ENC_BIN))    dut   (.clk(clk), .rst(rst), .x(x), .z(z_b));
  seq0101_det #(.ENC(seq_det_pkg::ENC_GRAY))   dut_g (.clk(clk), .rst(rst), .x(x), .z(z_g));
  seq0101_det #(.ENC(seq_det_pkg::ENC_ONEHOT)) dut_h (.clk(clk), .rst(rst), .x(x), .z(z_h));

  task automatic check1(string req, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: z=%b expected %b", req, name, $time, act, exp);
    end
  endtask

  // apply one bit (with reset level), compare all encodings, then advance the model
  task automatic step(logic b, logic r, string req);
    logic exp;
    @(negedge clk);
    rst = r;
    x   = b;
    #1;
    exp = !r && (seen >= 3) && ({hist, b} == 4'b0101);
    check1(req, "bin",    z_b, exp);
    check1(req, "gray",   z_g, exp);
    check1(req, "onehot", z_h, exp);
    if (r) begin
      hist = '0;
      seen = 0;
    end else begin
      hist = {hist[1:0], b};
      seen++;
    end
  endtask

  task automatic bits(string s, string req);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", 1'b0, req);
  endtask

  initial begin
    #5_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, "R2");
    bits("101", "R1");          // nothing before reset can help
    step(1'b0, 1'b1, "R1");
    bits("0101", "R3");
    step(1'b0, 1'b1, "R1");
    bits("010101", "R4");       // matches at 4 and 6
    bits("0101010101", "R4");
    bits("1100101", "R5");
    bits("0011000101", "R5");
    bits("011010", "R5");
    bits("010", "R2");
    step(1'b1, 1'b1, "R2");     // would complete, but reset holds z low
    step(1'b1, 1'b0, "R1");
    bits("0100101", "R1");
    bits("010", "R1");
    step(1'b0, 1'b1, "R1");     // reset mid-pattern
    bits("1", "R1");            // must not match
    bits("0101", "R6");
    for (int n = 0; n < 3000; n++) begin
      logic r;
      r = ($urandom_range(0, 99) == 0);
      if (n % 50 < 12) step(n[0], r, "R6");   // 0101.. bursts
      else             step(1'($urandom), r, "R7");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule